// File: doc/BRIEF.md
# Serial Port with Even-Parity Framing on a Peripheral Bus

This block is an asynchronous serial port that hangs on an APB peripheral bus. It has one transmit pin and one receive pin and no flow-control lines. Every character is framed the same way: a low start bit, eight data bits with the least significant bit first, an even-parity bit and one high stop bit. The bit timing runs on a separate serial clock. A divider in that clock domain produces a tick at sixteen times the baud rate, which is 9600 bit/s by default. The bus logic runs on the bus clock. All control that passes between the two clocks uses toggle handshakes through two-flop synchronizers.

Software first sets the direction in a control register: either the transmitter or the receiver is active, never both. In transmit mode, a write to the data register sends one frame. In receive mode, each complete frame leaves its byte in a readable data register and pulls an active-low interrupt. The interrupt is held inactive in every cycle in which the port is selected on the bus. A parity mismatch or a low stop bit sets a sticky error flag. Reading the data register consumes the byte and clears that flag.

Top module: `serial_port_apb`

## Requirements
- R1: A transmitted frame on `txd` is 0 (start), then data bits 0 to 7, then the even-parity bit (XOR of the data bits), then 1 (stop). Each bit lasts 16·DIV serial-clock cycles, where DIV = SCLK_HZ/(16·BAUD). The line idles at 1.
- R2: A write to DATA (address 0x0) while CTRL bit 0 is 1 (transmit mode) and no frame is pending sends exactly one frame of that byte. STAT bit 2 (transmit busy) reads 1 from the cycle after the write until that frame has ended.
- R3: A write to DATA is ignored if transmit busy is 1 or CTRL bit 0 is 0. The frame in flight keeps its byte, and no further frame appears on `txd`.
- R4: In receive mode (CTRL bit 0 = 0), `rxd` is sampled on the 16× tick. A start bit is accepted only if it is still low at mid-bit, so a low pulse shorter than half a bit yields no byte. Each later bit is sampled at its centre. A complete frame leaves its byte in DATA and sets STAT bit 0 (receive full).
- R5: `intn` is 0 when receive full is 1 and `psel` is 0. It is 1 in every cycle in which `psel` is 1.
- R6: A received parity bit that differs from the XOR of the received data bits, or a stop bit sampled as 0, sets STAT bit 1 (receive error). The byte is still stored and receive full is still set.
- R7: A read of DATA returns the received byte and clears receive full and receive error, so `intn` returns to 1.
- R8: In transmit mode, frames on `rxd` are ignored: receive full stays 0 and `intn` stays 1.
- R9: After reset, `txd` is 1, `intn` is 1, and CTRL (address 0x4) and STAT (address 0x8) read 0, which is receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| sclk | input | 1 | Serial bit-timing clock |
| rst | input | 1 | Synchronous active-high reset, seen in both clock domains |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address: DATA 0x0, CTRL 0x4, STAT 0x8 |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, registered in the setup phase |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| intn | output | 1 | Active-low receive interrupt |

## Verification
Two things can coincide in a single bus-clock cycle. One is a received byte arriving from the serial domain, which sets receive full and would pull the interrupt. The other is the port being selected on the bus, which must hold the interrupt high. The bench provokes this by holding `psel` high across the whole reception of a frame. It counts every bus-clock cycle in which `intn` goes low under select, and that count must stay zero. The interrupt must then fall in the first cycle after select is dropped, and STAT and DATA must report the byte.

// File: rtl/serial_port_pkg.sv
`timescale 1ns/1ps
package serial_port_pkg;
  localparam int OVS      = 16;   // samples per bit
  localparam int OFS_DATA = 'h0;
  localparam int OFS_CTRL = 'h4;
  localparam int OFS_STAT = 'h8;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_t;
endpackage

// File: rtl/serial_sync2.sv
`timescale 1ns/1ps
module serial_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/serial_tick_gen.sv
`timescale 1ns/1ps
module serial_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R1: the divider never leaves its range, so tick spacing is DIV cycles
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < DIV);
endmodule

// File: rtl/serial_tx_engine.sv
`timescale 1ns/1ps
module serial_tx_engine import serial_port_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] data,
  output logic       txd,
  output logic       busy,
  output logic       done
);
  logic       pend;
  logic [9:0] shift;   // data, parity, stop still to send
  logic [3:0] bitn;
  logic [3:0] sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      shift <= '1;
      bitn  <= '0;
      sub   <= '0;
      txd   <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) pend <= 1'b1;
      if (!busy && pend && tick) begin
        pend  <= 1'b0;
        shift <= {1'b1, ^data, data};
        txd   <= 1'b0;
        busy  <= 1'b1;
        bitn  <= '0;
        sub   <= '0;
      end else if (busy && tick) begin
        if (sub == 4'(OVS - 1)) begin
          sub <= '0;
          if (bitn == 4'd10) begin
            busy <= 1'b0;
            txd  <= 1'b1;
            done <= 1'b1;
          end else begin
            bitn  <= bitn + 1'b1;
            txd   <= shift[0];
            shift <= {1'b1, shift[9:1]};
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  // R1: line idles high whenever no frame is in progress
  p_tx_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R1: every frame opens with a low start bit
  p_tx_start_low_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/serial_rx_engine.sv
`timescale 1ns/1ps
module serial_rx_engine import serial_port_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] byte_q,
  output logic       err_q
);
  rx_state_t  state;
  logic [3:0] sub;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       par;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      sub    <= '0;
      bitn   <= '0;
      sh     <= '0;
      par    <= 1'b0;
      done   <= 1'b0;
      byte_q <= '0;
      err_q  <= 1'b0;
    end else if (!en) begin
      state <= RX_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rxd) begin
              state <= RX_START;
              sub   <= '0;
            end
          end
          RX_START: begin
            if (sub == 4'(OVS/2 - 1)) begin
              sub <= '0;
              if (!rxd) begin
                state <= RX_DATA;
                bitn  <= '0;
              end else begin
                state <= RX_IDLE;      // glitch: start not confirmed
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_DATA: begin
            if (sub == 4'(OVS - 1)) begin
              sub <= '0;
              sh  <= {rxd, sh[7:1]};
              if (bitn == 3'd7) state <= RX_PAR;
              else              bitn  <= bitn + 1'b1;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_PAR: begin
            if (sub == 4'(OVS - 1)) begin
              sub   <= '0;
              par   <= rxd;
              state <= RX_STOP;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_STOP: begin
            if (sub == 4'(OVS - 1)) begin
              sub    <= '0;
              state  <= RX_IDLE;
              done   <= 1'b1;
              byte_q <= sh;
              err_q  <= (par != ^sh) | !rxd;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R8: with the receiver disabled no frame is tracked and none completes
  p_rx_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state == RX_IDLE) && !done);
endmodule

// File: rtl/serial_port_apb.sv
`timescale 1ns/1ps
module serial_port_apb import serial_port_pkg::*; #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int SCLK_HZ = 1_843_200,
  parameter int BAUD    = 9600
) (
  input  logic              pclk,
  input  logic              sclk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              rxd,
  output logic              txd,
  output logic              intn
);
  localparam int DIV_RAW = SCLK_HZ / (BAUD * OVS);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;

  // ---------------- bus-clock domain ----------------
  logic       ctrl_tx;
  logic [7:0] tx_hold;
  logic       tx_req_tgl;
  logic       tx_ack_p;
  logic       tx_busy;
  logic       rx_tgl_p, rx_tgl_d;
  logic       rx_arrive;
  logic       rx_full, rx_err;
  logic [7:0] rx_data;

  // ---------------- serial-clock domain -------------
  logic       tick;
  logic       tx_mode_s;
  logic       req_s, req_d;
  logic       tx_start, tx_done, tx_eng_busy;
  logic       ack_tgl_s;
  logic       rxd_s;
  logic       rx_done;
  logic [7:0] rx_byte_s;
  logic       rx_err_s;
  logic       rx_tgl_s;

  logic wr_acc, rd_acc, setup;
  logic hit_data, hit_ctrl, hit_stat;
  logic wr_data, rd_data;

  assign setup    = psel && !penable;
  assign wr_acc   = psel && penable && pwrite;
  assign rd_acc   = psel && penable && !pwrite;
  assign hit_data = (paddr == ADDR_W'(OFS_DATA));
  assign hit_ctrl = (paddr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (paddr == ADDR_W'(OFS_STAT));
  assign wr_data  = wr_acc && hit_data;
  assign rd_data  = rd_acc && hit_data;

  assign tx_busy   = (tx_req_tgl != tx_ack_p);
  assign rx_arrive = (rx_tgl_p != rx_tgl_d);

  always_ff @(posedge pclk) begin
    if (rst) begin
      ctrl_tx    <= 1'b0;
      tx_hold    <= '0;
      tx_req_tgl <= 1'b0;
      rx_tgl_d   <= 1'b0;
      rx_full    <= 1'b0;
      rx_err     <= 1'b0;
      rx_data    <= '0;
      prdata     <= '0;
    end else begin
      rx_tgl_d <= rx_tgl_p;
      if (setup) begin
        if (hit_data)      prdata <= DATA_W'(rx_data);
        else if (hit_ctrl) prdata <= DATA_W'(ctrl_tx);
        else if (hit_stat) prdata <= DATA_W'({tx_busy, rx_err, rx_full});
        else               prdata <= '0;
      end
      if (wr_acc && hit_ctrl) ctrl_tx <= pwdata[0];
      if (wr_data && ctrl_tx && !tx_busy) begin
        tx_hold    <= pwdata[7:0];
        tx_req_tgl <= ~tx_req_tgl;
      end
      // a byte arriving in the same cycle as a DATA read wins
      if (rx_arrive) begin
        rx_full <= 1'b1;
        rx_data <= rx_byte_s;
        rx_err  <= rx_err_s | (rx_err & !rd_data);
      end else if (rd_data) begin
        rx_full <= 1'b0;
        rx_err  <= 1'b0;
      end
    end
  end

  assign intn = !(rx_full && !psel);

  serial_sync2 #(.RST_VAL(1'b0)) u_ack_sync (
    .clk(pclk), .rst(rst), .d(ack_tgl_s), .q(tx_ack_p));
  serial_sync2 #(.RST_VAL(1'b0)) u_rxt_sync (
    .clk(pclk), .rst(rst), .d(rx_tgl_s), .q(rx_tgl_p));

  // ---------------- serial-clock side ----------------
  serial_sync2 #(.RST_VAL(1'b0)) u_mode_sync (
    .clk(sclk), .rst(rst), .d(ctrl_tx), .q(tx_mode_s));
  serial_sync2 #(.RST_VAL(1'b0)) u_req_sync (
    .clk(sclk), .rst(rst), .d(tx_req_tgl), .q(req_s));
  serial_sync2 #(.RST_VAL(1'b1)) u_rxd_sync (
    .clk(sclk), .rst(rst), .d(rxd), .q(rxd_s));

  assign tx_start = req_s ^ req_d;

  always_ff @(posedge sclk) begin
    if (rst) begin
      req_d     <= 1'b0;
      ack_tgl_s <= 1'b0;
      rx_tgl_s  <= 1'b0;
    end else begin
      req_d <= req_s;
      if (tx_done) ack_tgl_s <= ~ack_tgl_s;
      if (rx_done) rx_tgl_s  <= ~rx_tgl_s;
    end
  end

  serial_tick_gen #(.DIV(DIV)) u_tick (
    .clk(sclk), .rst(rst), .tick(tick));

  serial_tx_engine u_tx (
    .clk(sclk), .rst(rst), .tick(tick), .start(tx_start), .data(tx_hold),
    .txd(txd), .busy(tx_eng_busy), .done(tx_done));

  serial_rx_engine u_rx (
    .clk(sclk), .rst(rst), .tick(tick), .en(!tx_mode_s), .rxd(rxd_s),
    .done(rx_done), .byte_q(rx_byte_s), .err_q(rx_err_s));

  // R2: an accepted DATA write makes the port busy in the next cycle
  p_busy_set_r2: assert property (@(posedge pclk) disable iff (rst)
    (wr_data && ctrl_tx && !tx_busy) |=> tx_busy);
  // R3: a DATA write during a pending frame leaves the held byte alone
  p_hold_stable_r3: assert property (@(posedge pclk) disable iff (rst)
    (wr_data && tx_busy) |=> $stable(tx_hold));
  // R3: a DATA write in receive mode raises no transmit request
  p_no_req_rxmode_r3: assert property (@(posedge pclk) disable iff (rst)
    (wr_data && !ctrl_tx) |=> $stable(tx_req_tgl));
  // R6: an error flag only exists together with a stored byte
  p_err_with_full_r6: assert property (@(posedge pclk) disable iff (rst)
    rx_err |-> rx_full);
  // R7: a DATA read without a new arrival empties the receive register
  p_clear_on_read_r7: assert property (@(posedge pclk) disable iff (rst)
    (rd_data && !rx_arrive) |=> !rx_full);
  // R1: the serial engine is idle whenever the bus side sees no request
  p_engine_idle_r1: assert property (@(posedge sclk) disable iff (rst)
    (!tx_eng_busy && (req_s == ack_tgl_s) && !tx_start) |-> txd);
endmodule

// File: tb/serial_port_apb_bench.sv
`timescale 1ns/1ps
module serial_port_apb_bench;
  localparam int DIV_B  = 2;               // 307200 / (16*9600)
  localparam int BIT_SC = 16 * DIV_B;      // serial clocks per bit
  localparam logic [3:0] A_DATA = 4'h0, A_CTRL = 4'h4, A_STAT = 4'h8;
  // [9] corrupt parity, [8] corrupt stop, [7:0] byte
  localparam logic [9:0] VECS [0:5] = '{10'h000, 10'h0FF, 10'h1A5,
                                        10'h25A, 10'h081, 10'h33C};

  logic       pclk = 1'b0, sclk = 1'b0, rst = 1'b1;
  logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0] paddr = '0;
  logic [7:0] pwdata = '0;
  logic [7:0] prdata;
  logic       rxd = 1'b1;
  logic       txd, intn;

  int n_cmp = 0, n_bad = 0, viol = 0;
  logic mon_en = 1'b0;

  always #2 pclk = ~pclk;
  always #5 sclk = ~sclk;

  serial_port_apb #(.ADDR_W(4), .DATA_W(8), .SCLK_HZ(307_200), .BAUD(9600))
  u_serial_port_apb (
    .pclk(pclk), .sclk(sclk), .rst(rst), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .rxd(rxd), .txd(txd), .intn(intn));

  always @(negedge pclk) if (mon_en && psel && !intn) viol++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BIT_SC) @(negedge sclk);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic bad_par, input logic bad_stop);
    @(negedge sclk);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(^b ^ bad_par);
    if (bad_stop) begin
      rxd = 1'b0; repeat (12 * DIV_B) @(negedge sclk);
      rxd = 1'b1; repeat (4 * DIV_B) @(negedge sclk);
    end else begin
      send_bit(1'b1);
    end
    send_bit(1'b1);
    repeat (20) @(negedge pclk);
  endtask

  task automatic capture_tx(output logic [10:0] cap);
    int guard = 0;
    cap = '1;
    @(negedge sclk);
    while (txd !== 1'b0 && guard < 20 * BIT_SC) begin
      guard++;
      @(negedge sclk);
    end
    repeat (BIT_SC / 2) @(negedge sclk);
    cap[0] = txd;
    for (int i = 1; i < 11; i++) begin
      repeat (BIT_SC) @(negedge sclk);
      cap[i] = txd;
    end
  endtask

  task automatic count_lows(input int bits, output int lows);
    lows = 0;
    for (int i = 0; i < bits * BIT_SC; i++) begin
      @(negedge sclk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [10:0] cap;
    int          n;

    repeat (10) @(negedge pclk);
    rst = 1'b0;
    repeat (10) @(negedge pclk);

    // R9 reset state
    chk("R9 txd idle", 32'(txd), 1);
    chk("R9 intn idle", 32'(intn), 1);
    apb_read(A_STAT, r); chk("R9 STAT", 32'(r), 0);
    apb_read(A_CTRL, r); chk("R9 CTRL", 32'(r), 0);

    // table walk, receive direction: R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      logic [7:0] b;
      logic       e;
      b = VECS[v][7:0];
      e = VECS[v][9] | VECS[v][8];
      send_rx(b, VECS[v][9], VECS[v][8]);
      chk("R5 intn low on byte", 32'(intn), 0);
      apb_read(A_STAT, r); chk("R4/R6 STAT after frame", 32'(r), 32'({1'b0, e, 1'b1}));
      apb_read(A_DATA, r); chk("R4 received byte", 32'(r), 32'(b));
      @(negedge pclk);
      chk("R7 intn released", 32'(intn), 1);
      apb_read(A_STAT, r); chk("R7 STAT cleared", 32'(r), 0);
    end

    // R4: short low pulse on rxd is no start bit
    @(negedge sclk); rxd = 1'b0;
    repeat (4 * DIV_B) @(negedge sclk); rxd = 1'b1;
    repeat (12 * BIT_SC) @(negedge sclk);
    apb_read(A_STAT, r); chk("R4 glitch rejected", 32'(r), 0);
    chk("R4 glitch intn", 32'(intn), 1);

    // R5: select held across a byte arrival
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = A_STAT;
    viol = 0; mon_en = 1'b1;
    send_rx(8'h96, 1'b0, 1'b0);
    mon_en = 1'b0;
    chk("R5 intn low under select", 32'(viol), 0);
    psel = 0;
    @(negedge pclk);
    chk("R5 intn after select drop", 32'(intn), 0);
    apb_read(A_STAT, r); chk("R5 STAT", 32'(r), 1);
    apb_read(A_DATA, r); chk("R5 byte", 32'(r), 32'h96);

    // table walk, transmit direction: R1 R2
    apb_write(A_CTRL, 8'h01);
    apb_read(A_CTRL, r); chk("R9 CTRL readback", 32'(r), 1);
    repeat (10) @(negedge sclk);
    for (int v = 0; v < 6; v++) begin
      logic [7:0] b;
      b = VECS[v][7:0];
      apb_write(A_DATA, b);
      capture_tx(cap);
      chk("R1 frame bits", 32'(cap), 32'({1'b1, ^b, b, 1'b0}));
      repeat (BIT_SC) @(negedge sclk);
      repeat (10) @(negedge pclk);
      apb_read(A_STAT, r); chk("R2 busy cleared", 32'(r), 0);
    end

    // R1: start bit length
    apb_write(A_DATA, 8'hA5);
    @(negedge sclk);
    n = 0;
    while (txd !== 1'b0 && n < 20 * BIT_SC) begin n++; @(negedge sclk); end
    n = 0;
    while (txd === 1'b0) begin n++; @(negedge sclk); end
    chk("R1 bit length", 32'(n), 32'(BIT_SC));
    repeat (12 * BIT_SC) @(negedge sclk);

    // R2 busy flag, R3 write while busy
    apb_write(A_DATA, 8'h5A);
    apb_read(A_STAT, r); chk("R2 busy set", 32'(r), 32'h4);
    apb_write(A_DATA, 8'hFF);
    capture_tx(cap);
    chk("R3 in-flight byte kept", 32'(cap), 32'({1'b1, ^8'h5A, 8'h5A, 1'b0}));
    count_lows(3, n);
    chk("R3 no second frame", 32'(n), 0);
    apb_read(A_STAT, r); chk("R3 STAT idle", 32'(r), 0);

    // R8: receive ignored in transmit mode
    send_rx(8'h77, 1'b0, 1'b0);
    chk("R8 intn high", 32'(intn), 1);
    apb_read(A_STAT, r); chk("R8 STAT", 32'(r), 0);

    // R3: DATA write in receive mode sends nothing
    apb_write(A_CTRL, 8'h00);
    apb_write(A_DATA, 8'h3C);
    count_lows(13, n);
    chk("R3 rx-mode write ignored", 32'(n), 0);
    apb_read(A_STAT, r); chk("R3 rx-mode STAT", 32'(r), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule